// File: doc/BRIEF.md
# Magnitude to dBFS converter

This block turns an unsigned 16-bit channel magnitude into a power reading in decibels relative to the full scale of a 16-bit signed sample. A magnitude of 32767 reads 0 dBFS. The result is a signed fixed-point number in tenths of a dB, so -43.0 dB appears as -430. It sits after a channelizer's magnitude stage and feeds whatever logs or displays channel levels.

The integer part of the base-2 logarithm comes from the position of the leading one. The fractional part comes from a 33-point table of log2(1+k/32), interpolated linearly on the ten bits below the selected table index. A constant multiply converts the log2 value to tenths of a dB and subtracts the full-scale offset. Every magnitude bit takes part in the result, so small inputs keep fine resolution and no display floor is applied. A zero magnitude cannot be converted, and it yields a fixed sentinel.

The datapath is a three-stage pipeline. It accepts one magnitude on every clock cycle.

Top module: `mag_dbfs_conv`

## Requirements
- R1: The result is 200·log10(m/32767) rounded to tenths of a dB, so m = 32767 gives exactly 0 and m = 65535 gives 60.
- R2: A valid input of m = 0 gives the sentinel -999 (that is, -99.9 dB).
- R3: For every nonzero m from 1 to 65535, out_db differs from 200·log10(m/32767) by no more than 2 tenths (0.2 dB).
- R4: out_valid equals in_valid delayed by exactly three clock cycles, and a new input may be given on every cycle.
- R5: No floor clamps the result. m = 1 reads -903, m = 67 reads near -538, m = 117 near -490 and m = 232 near -430.
- R6: Small magnitudes are resolved. out_db never decreases as m rises by one, and m = 232 reads more than 10 dB above m = 67.
- R7: When rst is high at a clock edge, out_valid is low after that edge.
- R8: For a nonzero input, out_db lies within -903 to 61.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_mag as a magnitude to convert |
| in_mag | input | 16 | Unsigned channel magnitude |
| out_valid | output | 1 | Marks out_db as a result, three cycles after in_valid |
| out_db | output | 12 | Signed level in tenths of a dB relative to 32767 |

## Verification
The bench first converts a short list of magnitudes. That list includes 1, 2, 67, 117 and 232 to expose a floor or a coarse bin, 255 and 256 to expose a byte-boundary fault, and 32767 and 65535 to pin the reference point. It then feeds every magnitude from 0 to 65535 in order, one per cycle, with a bubble now and then. A real-valued logarithm checks each result within 0.2 dB. This sweep catches table, interpolation and leading-one errors at every exponent. The ordered sweep also exposes any loss of monotonicity between neighbours, and the bubbles show whether the valid strobe tracks its data through the pipeline.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
    localparam int MAG_W   = 16;
    localparam int EXP_W   = $clog2(MAG_W);
    localparam int IDX_W   = 5;
    localparam int TBL_N   = 1 << IDX_W;
    localparam int FRAC_W  = MAG_W - 1 - IDX_W;
    localparam int LG_FRAC = 16;
    localparam int LG_W    = EXP_W + LG_FRAC;
    localparam int K_FRAC  = 10;
    localparam int K_W     = 16;
    localparam int SHIFT   = LG_FRAC + K_FRAC;
    localparam int ACC_W   = LG_W + K_W + 2;
    localparam int DB_W    = 12;

    // tenths of a dB per octave: 200*log10(2), Q.K_FRAC
    localparam longint K_Q    = longint'(60.2059991328 * 1024.0);
    // 200*log10(32767) in Q.SHIFT
    localparam longint OFS_Q  = longint'(903.0873362 * 67108864.0);
    localparam longint HALF_Q = longint'(1) << (SHIFT - 1);

    localparam logic signed [DB_W-1:0] SENTINEL = -12'sd999;

    typedef struct packed {
        logic               vld;
        logic               zero;
        logic [EXP_W-1:0]   ex;
        logic [IDX_W-1:0]   idx;
        logic [FRAC_W-1:0]  t;
    } s1_t;

    typedef struct packed {
        logic              vld;
        logic              zero;
        logic [LG_W-1:0]   lg;
    } s2_t;

    // log2(1 + i/TBL_N) in Q.LG_FRAC by repeated squaring, integer only
    function automatic logic [LG_FRAC:0] frac_log2(input int i);
        longint y;
        logic [LG_FRAC:0] r;
        r = '0;
        if (i >= TBL_N) begin
            r = (LG_FRAC+1)'(1) << LG_FRAC;
        end else begin
            y = longint'(TBL_N + i) << (30 - IDX_W);
            for (int k = 0; k < LG_FRAC; k++) begin
                y = (y * y) >>> 30;
                r = r << 1;
                if (y >= (longint'(1) << 31)) begin
                    r[0] = 1'b1;
                    y = y >>> 1;
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/mdb_lod.sv
module mdb_lod
    import mdb_pkg::*;
(
    input  logic [MAG_W-1:0]  mag,
    output logic [EXP_W-1:0]  ex,
    output logic [IDX_W-1:0]  idx,
    output logic [FRAC_W-1:0] t
);
    logic [MAG_W-1:0] norm;

    always_comb begin
        ex = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) ex = EXP_W'(i);
        end
        norm = mag << (EXP_W'(MAG_W - 1) - ex);
    end

    assign idx = norm[MAG_W-2 -: IDX_W];
    assign t   = norm[FRAC_W-1:0];
endmodule

// File: rtl/mdb_log2.sv
module mdb_log2
    import mdb_pkg::*;
(
    input  logic [EXP_W-1:0]  ex,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FRAC_W-1:0] t,
    output logic [LG_W-1:0]   lg
);
    localparam int STEP_W = LG_FRAC + FRAC_W + 1;

    logic [LG_FRAC:0] tbl [0:TBL_N];

    for (genvar g = 0; g <= TBL_N; g++) begin : g_tbl
        localparam logic [LG_FRAC:0] VAL = frac_log2(g);
        assign tbl[g] = VAL;
    end

    logic [IDX_W:0]   nxt;
    logic [LG_FRAC:0] lo, hi, diff, f;
    logic [STEP_W-1:0] step;

    always_comb begin
        nxt  = {1'b0, idx} + (IDX_W+1)'(1);
        lo   = tbl[idx];
        hi   = tbl[nxt];
        diff = hi - lo;
        step = STEP_W'(diff) * STEP_W'(t);
        f    = lo + (LG_FRAC+1)'(step >> FRAC_W);
        lg   = {ex, f[LG_FRAC-1:0]};
    end
endmodule

// File: rtl/mdb_scale.sv
module mdb_scale
    import mdb_pkg::*;
(
    input  logic [LG_W-1:0]        lg,
    output logic signed [DB_W-1:0] db
);
    logic [ACC_W-1:0]        prod;
    logic signed [ACC_W-1:0] acc, sh;

    always_comb begin
        prod = ACC_W'(lg) * ACC_W'(K_Q);
        acc  = $signed(prod - ACC_W'(OFS_Q) + ACC_W'(HALF_Q));
        sh   = acc >>> SHIFT;
        db   = sh[DB_W-1:0];
    end
endmodule

// File: rtl/mag_dbfs_conv.sv
module mag_dbfs_conv
    import mdb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [MAG_W-1:0]       in_mag,
    output logic                   out_valid,
    output logic signed [DB_W-1:0] out_db
);
    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;
    logic signed [DB_W-1:0] db_d;

    logic [EXP_W-1:0]  lod_ex;
    logic [IDX_W-1:0]  lod_idx;
    logic [FRAC_W-1:0] lod_t;
    logic [LG_W-1:0]   lg_d;

    mdb_lod u_lod (
        .mag (in_mag),
        .ex  (lod_ex),
        .idx (lod_idx),
        .t   (lod_t)
    );

    always_comb begin
        s1_d.vld  = in_valid;
        s1_d.zero = (in_mag == '0);
        s1_d.ex   = lod_ex;
        s1_d.idx  = lod_idx;
        s1_d.t    = lod_t;
    end

    mdb_log2 u_log2 (
        .ex  (s1_q.ex),
        .idx (s1_q.idx),
        .t   (s1_q.t),
        .lg  (lg_d)
    );

    always_comb begin
        s2_d.vld  = s1_q.vld;
        s2_d.zero = s1_q.zero;
        s2_d.lg   = lg_d;
    end

    mdb_scale u_scale (
        .lg (s2_q.lg),
        .db (db_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '0;
            s2_q      <= '0;
            out_valid <= 1'b0;
            out_db    <= '0;
        end else begin
            s1_q      <= s1_d;
            s2_q      <= s2_d;
            out_valid <= s2_q.vld;
            out_db    <= s2_q.zero ? SENTINEL : db_d;
        end
    end
endmodule

// File: rtl/mag_dbfs_chk.sv
module mag_dbfs_chk
    import mdb_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [MAG_W-1:0]       in_mag,
    input logic                   out_valid,
    input logic signed [DB_W-1:0] out_db
);
    logic [1:0] since;

    always_ff @(posedge clk) begin
        if (rst) since <= '0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_zero_sentinel_R2: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && $past(in_valid, 3) && $past(in_mag, 3) == '0)
        |-> (out_db == SENTINEL));

    assert_full_scale_R1: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && $past(in_valid, 3) && $past(in_mag, 3) == MAG_W'(32767))
        |-> (out_db == '0));

    assert_range_R8: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && $past(in_valid, 3) && $past(in_mag, 3) != '0)
        |-> (out_db >= -12'sd903 && out_db <= 12'sd61));

    assert_no_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && $past(in_valid, 3) && $past(in_mag, 3) == MAG_W'(1))
        |-> (out_db <= -12'sd900));

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind mag_dbfs_conv mag_dbfs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mag    (in_mag),
    .out_valid (out_valid),
    .out_db    (out_db)
);

// File: tb/mag_dbfs_conv_test.sv
`timescale 1ns/1ps
module mag_dbfs_conv_test;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [15:0]       in_mag = '0;
    logic              out_valid;
    logic signed [11:0] out_db;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // expectation pipe, three deep
    bit pv [3];
    int pm [3];
    int prev_m   = -10;
    int prev_out = 0;
    int got67 = 0, got117 = 0, got232 = 0;

    always #2 clk = ~clk;

    mag_dbfs_conv uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mag    (in_mag),
        .out_valid (out_valid),
        .out_db    (out_db)
    );

    task automatic fail(input string req, input int act, input int exp_v);
        bad++;
        $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    endtask

    task automatic check_out();
        int o;
        real r, d;
        o = int'(out_db);
        total++;
        if (out_valid !== pv[2]) begin
            fail("R4 valid", int'(out_valid), int'(pv[2]));
            return;
        end
        if (!pv[2]) return;
        if (pm[2] == 0) begin
            if (o != -999) fail("R2 zero sentinel", o, -999);
            return;
        end
        r = 200.0 * $log10(real'(pm[2]) / 32767.0);
        d = real'(o) - r;
        if (d < 0.0) d = -d;
        if (d > 2.0) fail("R3 accuracy", o, int'(r));
        if (pm[2] == 32767 && o != 0)  fail("R1 full scale", o, 0);
        if (pm[2] == 65535 && o != 60) fail("R1 top", o, 60);
        if (pm[2] == 1 && o != -903)   fail("R5 no floor", o, -903);
        if (o < -903 || o > 61)        fail("R8 range", o, -903);
        if (pm[2] == prev_m + 1 && o < prev_out) fail("R6 monotonic", o, prev_out);
        if (pm[2] == 67)  got67  = o;
        if (pm[2] == 117) got117 = o;
        if (pm[2] == 232) got232 = o;
        prev_m   = pm[2];
        prev_out = o;
    endtask

    task automatic step(input bit v, input int m);
        @(negedge clk);
        check_out();
        pv[2] = pv[1]; pm[2] = pm[1];
        pv[1] = pv[0]; pm[1] = pm[0];
        pv[0] = v;     pm[0] = m;
        in_valid = v;
        in_mag   = 16'(m);
    endtask

    initial begin
        int spot [10] = '{0, 1, 2, 67, 117, 232, 255, 256, 32767, 65535};
        for (int i = 0; i < 3; i++) begin pv[i] = 0; pm[i] = 0; end
        repeat (4) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) fail("R7 reset", int'(out_valid), 0);
        rst = 1'b0;

        // spot values, then a bubble
        for (int i = 0; i < 10; i++) step(1'b1, spot[i]);
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b0, 0);
        total++;
        if (got232 - got67 <= 100) fail("R6 resolution 232 vs 67", got232 - got67, 101);
        total++;
        if (got67 < -540 || got67 > -536) fail("R5 m=67", got67, -538);
        total++;
        if (got117 < -492 || got117 > -488) fail("R5 m=117", got117, -490);

        // full sweep with occasional bubbles
        prev_m = -10;
        for (int m = 0; m < 65536; m++) begin
            if (m % 97 == 50) step(1'b0, 0);
            step(1'b1, m);
        end
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b0, 0);

        // reset mid-stream clears the valid output
        step(1'b1, 1000);
        step(1'b1, 2000);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) fail("R7 reset mid-stream", int'(out_valid), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule